// File: doc/BRIEF.md
# Warp Issue Scheduler for a Lane-Sliced SIMD Pipeline

This block feeds a SIMD execution pipeline from a pool of resident warps. Each warp bundles 32 threads that share a single program counter. The pipeline has 8 lanes, and each lane is bound to a fixed set of threads: lane k handles the threads whose index equals k modulo 8. A warp instruction therefore passes through the lanes in 4 consecutive beats. On every beat the scheduler presents, for each lane, the thread it serves and the register-file row that thread uses. Because every thread keeps its registers in the register file, changing from one warp to another costs nothing.

Each warp holds a PC, a ready flag and a parked flag. A warp has at most one instruction in the pipeline at any time, so the scheduler needs no dependency interlock. When the current instruction reaches its last beat, the warp's PC advances by one. The warp then goes back to the ready pool, unless a data-cache miss was signalled, in which case it is parked until its memory reply arrives. The choice among ready warps is round-robin, starting just after the warp issued last. Other warps keep the pipeline busy while one waits on memory. When no warp is ready, the pipeline receives a bubble.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no warp is resident and `issueValid` stays low until a warp is launched.
- R2: A launch of a warp that is not resident makes it eligible, and its first issue carries the launch PC. A launch aimed at a warp that is ready, parked or in flight changes nothing, including its PC.
- R3: An issued instruction occupies exactly 4 consecutive cycles with `issueBeat` counting 0, 1, 2, 3. `issueWarp` stays the same across those cycles.
- R4: On beat b, lane l carries thread ID b*8+l on `laneThread[l*5 +: 5]`. It carries register row warp*32+threadID on `laneReg[l*10 +: 10]`, with the warp in the upper 5 bits.
- R5: The next warp chosen is the first ready warp after the last issued one in increasing index order, wrapping from 31 to 0. After reset the search starts at warp 0.
- R6: When another warp is ready, its beat 0 follows the previous instruction's beat 3 in the very next cycle.
- R7: A warp completing beat 3 becomes eligible again only in the following cycle. A lone warp therefore shows exactly one idle cycle between its instructions, so issue starts are 5 cycles apart.
- R8: Each completed instruction advances that warp's PC by one.
- R9: If `memMiss` is high in the cycle of a warp's beat 3, that warp is parked and is not issued again until a reply for it arrives.
- R10: A reply for a parked warp makes it eligible from the next cycle, so with an idle pipeline its beat 0 appears two cycles after the reply cycle. A reply for a warp that is not parked has no effect.
- R11: With no ready warp the scheduler issues a bubble: `issueValid` is low and all lane outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| launchValid | input | 1 | Launch a warp this cycle |
| launchWarp | input | 5 | Warp to launch |
| launchPc | input | 16 | Starting PC of the launched warp |
| memMiss | input | 1 | Current instruction missed in the data cache (sampled on beat 3) |
| replyValid | input | 1 | Memory reply arriving this cycle |
| replyWarp | input | 5 | Warp the reply belongs to |
| issueValid | output | 1 | A beat is being issued |
| issueWarp | output | 5 | Warp being issued |
| issuePc | output | 16 | PC of the instruction being issued |
| issueBeat | output | 2 | Beat index 0..3 |
| laneThread | output | 40 | Per-lane thread ID, 5 bits per lane |
| laneReg | output | 80 | Per-lane register row, 10 bits per lane |

## Verification
The conditions hardest to reach from the ports are a parked warp waking up and the exact cycle in which a memory reply makes a warp eligible. Both are hidden whenever other warps keep the pipeline busy. The stimulus launches a single warp and raises the miss indication on the cycle its last beat is shown. It then holds the pipeline idle and sends first a reply for an unrelated warp and then the real reply on a chosen cycle, so the two-cycle wake-up can be observed without interference. A second scenario parks one of three warps while the other two continue to alternate, and a full pool of 32 warps exercises wrap-around and back-to-back issue.

// File: rtl/wi_pkg.sv
package wi_pkg;
  // Strobes from the control half to the warp-state datapath
  typedef struct packed {
    logic pickEn;    // a warp is chosen this cycle and leaves the ready pool
    logic issueEn;   // a beat of curWarp is on the pipeline
    logic lastBeat;  // this beat completes curWarp's instruction
  } wiStrobe_t;
endpackage

// File: rtl/wi_rr_arb.sv
module wi_rr_arb #(
  parameter int N = 32,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] lastIdx,
  output logic         grantValid,
  output logic [W-1:0] grantIdx
);
  // Scan from farthest to nearest so the nearest requester after lastIdx wins
  always_comb begin
    grantValid = 1'b0;
    grantIdx   = '0;
    for (int i = N; i >= 1; i--) begin
      if (req[(int'(lastIdx) + i) % N]) begin
        grantValid = 1'b1;
        grantIdx   = W'((int'(lastIdx) + i) % N);
      end
    end
  end
endmodule

// File: rtl/wi_ctrl.sv
module wi_ctrl
  import wi_pkg::*;
#(
  parameter int NUM_WARPS = 32,
  parameter int BEATS     = 4,
  localparam int WID_W  = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WARPS-1:0] readyVec,
  output wiStrobe_t            strb,
  output logic [WID_W-1:0]     pickWarp,
  output logic [WID_W-1:0]     curWarp,
  output logic [BEAT_W-1:0]    beat
);
  logic             busy;
  logic [WID_W-1:0] lastPtr;
  logic             grantValid;
  logic [WID_W-1:0] grantIdx;
  logic             lastNow;
  logic             slotFree;

  wi_rr_arb #(.N(NUM_WARPS)) u_arb (
    .req       (readyVec),
    .lastIdx   (lastPtr),
    .grantValid(grantValid),
    .grantIdx  (grantIdx)
  );

  assign lastNow  = busy && (beat == BEAT_W'(BEATS - 1));
  assign slotFree = !busy || lastNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      beat    <= '0;
      curWarp <= '0;
      lastPtr <= WID_W'(NUM_WARPS - 1);
    end else if (slotFree) begin
      busy <= grantValid;
      beat <= '0;
      if (grantValid) begin
        curWarp <= grantIdx;
        lastPtr <= grantIdx;
      end
    end else begin
      beat <= beat + BEAT_W'(1);
    end
  end

  always_comb begin
    strb.pickEn   = slotFree && grantValid;
    strb.issueEn  = busy;
    strb.lastBeat = lastNow;
  end
  assign pickWarp = grantIdx;
endmodule

// File: rtl/wi_datapath.sv
module wi_datapath
  import wi_pkg::*;
#(
  parameter int NUM_WARPS = 32,
  parameter int WARP_SIZE = 32,
  parameter int NUM_LANES = 8,
  parameter int PC_W      = 16,
  localparam int BEATS  = WARP_SIZE / NUM_LANES,
  localparam int WID_W  = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int TID_W  = (WARP_SIZE > 1) ? $clog2(WARP_SIZE) : 1,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int REG_W  = WID_W + TID_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  wiStrobe_t                  strb,
  input  logic [WID_W-1:0]           pickWarp,
  input  logic [WID_W-1:0]           curWarp,
  input  logic [BEAT_W-1:0]          beat,
  input  logic                       launchValid,
  input  logic [WID_W-1:0]           launchWarp,
  input  logic [PC_W-1:0]            launchPc,
  input  logic                       memMiss,
  input  logic                       replyValid,
  input  logic [WID_W-1:0]           replyWarp,
  output logic [NUM_WARPS-1:0]       readyVec,
  output logic [PC_W-1:0]            issuePc,
  output logic [NUM_LANES*TID_W-1:0] laneThread,
  output logic [NUM_LANES*REG_W-1:0] laneReg
);
  logic [PC_W-1:0]      pcs [NUM_WARPS];
  logic [NUM_WARPS-1:0] ready;
  logic [NUM_WARPS-1:0] parked;
  logic [NUM_WARPS-1:0] inFlight;
  logic [NUM_WARPS-1:0] resident;

  always_comb begin
    inFlight = '0;
    if (strb.issueEn) inFlight[curWarp] = 1'b1;
    resident = ready | parked | inFlight;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < NUM_WARPS; w++) pcs[w] <= '0;
      ready  <= '0;
      parked <= '0;
    end else begin
      for (int w = 0; w < NUM_WARPS; w++) begin
        if (strb.pickEn && pickWarp == WID_W'(w)) ready[w] <= 1'b0;
        if (strb.lastBeat && curWarp == WID_W'(w)) begin
          pcs[w] <= pcs[w] + PC_W'(1);
          if (memMiss) parked[w] <= 1'b1;
          else         ready[w]  <= 1'b1;
        end
        if (replyValid && replyWarp == WID_W'(w) && parked[w]) begin
          parked[w] <= 1'b0;
          ready[w]  <= 1'b1;
        end
        if (launchValid && launchWarp == WID_W'(w) && !resident[w]) begin
          ready[w] <= 1'b1;
          pcs[w]   <= launchPc;
        end
      end
    end
  end

  assign readyVec = ready;
  assign issuePc  = strb.issueEn ? pcs[curWarp] : '0;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [TID_W-1:0] tid;
    assign tid = TID_W'(int'(beat) * NUM_LANES + l);
    assign laneThread[l*TID_W +: TID_W] = strb.issueEn ? tid : '0;
    assign laneReg[l*REG_W +: REG_W]    = strb.issueEn ? {curWarp, tid} : '0;
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wi_pkg::*;
#(
  parameter int NUM_WARPS = 32,
  parameter int WARP_SIZE = 32,
  parameter int NUM_LANES = 8,
  parameter int PC_W      = 16,
  localparam int BEATS  = WARP_SIZE / NUM_LANES,
  localparam int WID_W  = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int TID_W  = (WARP_SIZE > 1) ? $clog2(WARP_SIZE) : 1,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int REG_W  = WID_W + TID_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       launchValid,
  input  logic [WID_W-1:0]           launchWarp,
  input  logic [PC_W-1:0]            launchPc,
  input  logic                       memMiss,
  input  logic                       replyValid,
  input  logic [WID_W-1:0]           replyWarp,
  output logic                       issueValid,
  output logic [WID_W-1:0]           issueWarp,
  output logic [PC_W-1:0]            issuePc,
  output logic [BEAT_W-1:0]          issueBeat,
  output logic [NUM_LANES*TID_W-1:0] laneThread,
  output logic [NUM_LANES*REG_W-1:0] laneReg
);
  wiStrobe_t            strb;
  logic [WID_W-1:0]     pickWarp;
  logic [WID_W-1:0]     curWarp;
  logic [BEAT_W-1:0]    beat;
  logic [NUM_WARPS-1:0] readyVec;

  wi_ctrl #(.NUM_WARPS(NUM_WARPS), .BEATS(BEATS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .readyVec(readyVec),
    .strb    (strb),
    .pickWarp(pickWarp),
    .curWarp (curWarp),
    .beat    (beat)
  );

  wi_datapath #(
    .NUM_WARPS(NUM_WARPS), .WARP_SIZE(WARP_SIZE),
    .NUM_LANES(NUM_LANES), .PC_W(PC_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .pickWarp   (pickWarp),
    .curWarp    (curWarp),
    .beat       (beat),
    .launchValid(launchValid),
    .launchWarp (launchWarp),
    .launchPc   (launchPc),
    .memMiss    (memMiss),
    .replyValid (replyValid),
    .replyWarp  (replyWarp),
    .readyVec   (readyVec),
    .issuePc    (issuePc),
    .laneThread (laneThread),
    .laneReg    (laneReg)
  );

  assign issueValid = strb.issueEn;
  assign issueWarp  = strb.issueEn ? curWarp : '0;
  assign issueBeat  = strb.issueEn ? beat : '0;
endmodule

// File: rtl/warp_issue_chk.sv
module warp_issue_chk #(
  parameter int NUM_WARPS = 32,
  parameter int WARP_SIZE = 32,
  parameter int NUM_LANES = 8,
  localparam int BEATS  = WARP_SIZE / NUM_LANES,
  localparam int WID_W  = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int TID_W  = (WARP_SIZE > 1) ? $clog2(WARP_SIZE) : 1,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int REG_W  = WID_W + TID_W
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       issueValid,
  input logic [WID_W-1:0]           issueWarp,
  input logic [BEAT_W-1:0]          issueBeat,
  input logic [NUM_LANES*TID_W-1:0] laneThread,
  input logic [NUM_LANES*REG_W-1:0] laneReg
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  p_beat_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueBeat != LAST) |=>
      (issueValid && issueBeat == ($past(issueBeat) + BEAT_W'(1)) &&
       issueWarp == $past(issueWarp)));

  p_mid_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueBeat != '0) |-> $past(issueValid));

  p_no_reissue_r7: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueBeat == LAST) |=>
      !(issueValid && issueWarp == $past(issueWarp)));

  p_idle_lanes_r11: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |-> (laneThread == '0 && laneReg == '0));

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_chk
    p_lane_tid_r4: assert property (@(posedge clk) disable iff (!rstN)
      issueValid |->
        laneThread[l*TID_W +: TID_W] == TID_W'(int'(issueBeat) * NUM_LANES + l));
    p_lane_row_r4: assert property (@(posedge clk) disable iff (!rstN)
      issueValid |->
        laneReg[l*REG_W +: REG_W] == {issueWarp, laneThread[l*TID_W +: TID_W]});
  end
endmodule

bind warp_issue_sched warp_issue_chk #(
  .NUM_WARPS(NUM_WARPS), .WARP_SIZE(WARP_SIZE), .NUM_LANES(NUM_LANES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .issueValid(issueValid),
  .issueWarp (issueWarp),
  .issueBeat (issueBeat),
  .laneThread(laneThread),
  .laneReg   (laneReg)
);

// File: tb/sim_warp_issue_sched.sv
`timescale 1ns/1ps
module sim_warp_issue_sched;
  localparam int NW = 32, WS = 32, NL = 8, PCW = 16;
  localparam int TW = 5, RW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic launchValid = 1'b0;
  logic [4:0] launchWarp = '0;
  logic [PCW-1:0] launchPc = '0;
  logic memMiss = 1'b0;
  logic replyValid = 1'b0;
  logic [4:0] replyWarp = '0;
  logic issueValid;
  logic [4:0] issueWarp;
  logic [PCW-1:0] issuePc;
  logic [1:0] issueBeat;
  logic [NL*TW-1:0] laneThread;
  logic [NL*RW-1:0] laneReg;

  int nChk = 0, nFail = 0;
  int cyc = 0;
  int logN = 0;
  int logWarp [256];
  int logPc   [256];
  int logCyc  [256];
  logic prevValid = 1'b0;
  int prevBeat = 0, prevWarp = 0;

  always #2.5 clk = ~clk;

  warp_issue_sched u0 (
    .clk(clk), .rstN(rstN), .launchValid(launchValid), .launchWarp(launchWarp),
    .launchPc(launchPc), .memMiss(memMiss), .replyValid(replyValid),
    .replyWarp(replyWarp), .issueValid(issueValid), .issueWarp(issueWarp),
    .issuePc(issuePc), .issueBeat(issueBeat), .laneThread(laneThread),
    .laneReg(laneReg)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Lane/beat monitor and issue log
  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      logN = 0;
      prevValid = 1'b0;
    end else begin
      if (issueValid) begin
        for (int l = 0; l < NL; l++) begin
          int t;
          t = int'(issueBeat) * NL + l;
          chk(int'(laneThread[l*TW +: TW]) == t, "R4 lane thread", int'(laneThread[l*TW +: TW]), t);
          chk(int'(laneReg[l*RW +: RW]) == int'(issueWarp) * WS + t, "R4 lane row",
              int'(laneReg[l*RW +: RW]), int'(issueWarp) * WS + t);
        end
        if (issueBeat == 2'd0 && logN < 256) begin
          logWarp[logN] = int'(issueWarp);
          logPc[logN]   = int'(issuePc);
          logCyc[logN]  = cyc;
          logN++;
        end
      end
      if (prevValid && prevBeat != 3) begin
        chk(issueValid && int'(issueBeat) == prevBeat + 1 && int'(issueWarp) == prevWarp,
            "R3 beat sequence", int'(issueBeat), prevBeat + 1);
      end
      prevValid = issueValid;
      prevBeat  = int'(issueBeat);
      prevWarp  = int'(issueWarp);
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic launch(input int w, input int pc);
    launchValid = 1'b1;
    launchWarp  = 5'(w);
    launchPc    = PCW'(pc);
    @(negedge clk);
    launchValid = 1'b0;
  endtask

  task automatic reply(input int w);
    replyValid = 1'b1;
    replyWarp  = 5'(w);
    @(negedge clk);
    replyValid = 1'b0;
  endtask

  // Raise memMiss during the last beat of warp w
  task automatic missOn(input int w);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (issueValid && int'(issueWarp) == w && issueBeat == 2'd3) break;
    end
    memMiss = 1'b1;
    @(negedge clk);
    memMiss = 1'b0;
  endtask

  task automatic waitLog(input int n);
    for (int i = 0; i < 600; i++) begin
      if (logN >= n) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    // R1: nothing issues after reset
    doReset();
    for (int i = 0; i < 6; i++) begin
      chk(!issueValid, "R1 idle after reset", int'(issueValid), 0);
      @(negedge clk);
    end

    // R2, R7, R8: lone warp, ignored relaunch
    doReset();
    launch(5, 100);
    waitLog(1);
    launch(5, 500);
    waitLog(4);
    chk(logN >= 4, "R2 lone warp issued", logN, 4);
    for (int k = 0; k < 4; k++) begin
      chk(logWarp[k] == 5, "R2 warp id", logWarp[k], 5);
      chk(logPc[k] == 100 + k, "R8 pc advance / R2 relaunch ignored", logPc[k], 100 + k);
      if (k > 0) chk(logCyc[k] - logCyc[k-1] == 5, "R7 lone warp gap", logCyc[k] - logCyc[k-1], 5);
    end

    // R5, R6: full pool, round robin with wrap, back-to-back
    doReset();
    for (int w = 0; w < NW; w++) launch(w, 1000 + w);
    waitLog(64);
    chk(logN >= 64, "R5 pool issued", logN, 64);
    for (int k = 0; k < 64; k++) begin
      chk(logWarp[k] == k % NW, "R5 round robin order", logWarp[k], k % NW);
      chk(logPc[k] == 1000 + (k % NW) + k / NW, "R8 pc per round", logPc[k], 1000 + (k % NW) + k / NW);
      if (k > 0) chk(logCyc[k] - logCyc[k-1] == 4, "R6 back-to-back", logCyc[k] - logCyc[k-1], 4);
    end

    // R9, R5, R10: park one of three warps
    doReset();
    launch(0, 0);
    launch(1, 10);
    launch(2, 20);
    missOn(1);
    begin
      int m;
      int seen;
      int found;
      m = logN;
      repeat (40) @(negedge clk);
      seen = 0;
      for (int k = m; k < logN; k++) begin
        if (logWarp[k] == 1) seen++;
        if (k > m) chk(logWarp[k] != logWarp[k-1], "R5 alternation while parked", logWarp[k], 2 - logWarp[k-1]);
      end
      chk(seen == 0, "R9 parked warp not issued", seen, 0);
      chk(logN - m >= 6, "R9 others keep issuing", logN - m, 6);
      m = logN;
      reply(1);
      repeat (20) @(negedge clk);
      found = -1;
      for (int k = m; k < logN; k++) if (found < 0 && logWarp[k] == 1) found = k;
      chk(found >= 0, "R10 woken warp issued", found, m);
      if (found >= 0) chk(logPc[found] == 11, "R8 pc after miss", logPc[found], 11);
    end

    // R9, R10, R11: exact wake-up timing with an idle pipeline
    doReset();
    launch(4, 7);
    missOn(4);
    for (int i = 0; i < 10; i++) begin
      chk(!issueValid, "R9 parked lone warp idle", int'(issueValid), 0);
      chk(laneThread == '0 && laneReg == '0, "R11 bubble lanes zero", int'(laneThread[TW-1:0]), 0);
      @(negedge clk);
    end
    reply(9);
    for (int i = 0; i < 8; i++) begin
      chk(!issueValid, "R10 stray reply ignored", int'(issueValid), 0);
      @(negedge clk);
    end
    replyValid = 1'b1;
    replyWarp  = 5'd4;
    @(negedge clk);
    replyValid = 1'b0;
    chk(!issueValid, "R10 not yet issued one cycle after reply", int'(issueValid), 0);
    @(negedge clk);
    chk(issueValid, "R10 issued two cycles after reply", int'(issueValid), 1);
    chk(int'(issueWarp) == 4, "R10 woken warp id", int'(issueWarp), 4);
    chk(issueBeat == 2'd0, "R10 starts at beat 0", int'(issueBeat), 0);
    chk(int'(issuePc) == 8, "R8 pc after parked instruction", int'(issuePc), 8);
    repeat (4) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule